// File: doc/BRIEF.md
# Multi-Mode Operand Fetch and Add Unit

This block executes one two-operand add per command. The source operand is found through one of ten addressing modes. The block adds that operand to a destination register and writes the sum back to the same register. It contains a small general-purpose register file. Register 0 is hard-wired to zero.

Operands that live in memory are fetched through a synchronous read port. The block holds a request with an address until the memory answers with a one-cycle valid strobe. A memory-indirect command makes two reads: the first returns a pointer and the second returns the operand. The post-increment and pre-decrement modes also update their base register by the access size.

A command is presented as decoded fields together with a one-cycle start strobe. The block is busy until it emits a one-cycle done pulse, and a new command is only accepted when the block is idle.

Top module: `opf_unit`

## Requirements
- R1: After reset every register reads zero, and busy, done and the memory request are all low.
- R2: Mode 0 (register) adds the register selected by the base field to the destination, and makes no memory request.
- R3: Mode 1 (immediate) adds the immediate field to the destination, and makes no memory request.
- R4: Mode 2 (displacement) reads memory at base + immediate. Mode 3 (register indirect) reads memory at base. In both modes the word read is added to the destination.
- R5: Mode 4 (indexed) reads memory at base + index. Mode 5 (direct) reads memory at the immediate field.
- R6: Mode 6 (memory indirect) first reads at base to obtain a pointer, then reads at that pointer; the second word read is the operand.
- R7: Mode 7 (post-increment) reads at the current base, then adds d to the base register.
- R8: Mode 8 (pre-decrement) subtracts d from the base register and reads at the decremented address.
- R9: Mode 9 (scaled) reads at immediate + base + (index shifted left by the size field). The size field encodes d: 0→1, 1→2, 2→4, 3→8.
- R10: When the destination equals the auto-modified base register, the sum is written and the base update is discarded.
- R11: Register 0 always reads as zero, and a command with destination 0 leaves it zero.
- R12: A memory request keeps its address stable until valid is seen. Done is high for exactly one cycle per command, and at that point the write-back is already visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command strobe, accepted only when idle |
| mode_i | input | 4 | Addressing mode code (0..9) |
| rd_i | input | RIW | Destination register |
| rb_i | input | RIW | Base / source register |
| rx_i | input | RIW | Index register |
| imm_i | input | DW | Immediate, displacement or absolute address |
| size_i | input | 2 | log2 of access size d |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | DW | Memory read address |
| mem_rdata_i | input | DW | Memory read data |
| mem_valid_i | input | 1 | Read data valid strobe |

## Verification
The bench targets the following corner cases, each with the symptom a faulty design would show:
- **Memory indirect:** a design that reused the first address, or added the pointer itself, would show a wrong second request address or a wrong sum.
- **Base updates:** the post-increment and pre-decrement cases are checked both by the request address and by the base register's new value. A design that updated the base at the wrong point would read one access size off.
- **Destination equals base:** this case separates a design whose base update overrides the sum.
- **Register 0:** writes aimed at register 0 are checked through a later indirect read, which would request a non-zero address if the write had stuck.
- **Scaled index:** this case catches a multiply by the size code instead of by d.

// File: rtl/opf_pkg.sv
package opf_pkg;
  typedef enum logic [3:0] {
    M_REG  = 4'd0,
    M_IMM  = 4'd1,
    M_DISP = 4'd2,
    M_RIND = 4'd3,
    M_IDX  = 4'd4,
    M_DIR  = 4'd5,
    M_MIND = 4'd6,
    M_AINC = 4'd7,
    M_ADEC = 4'd8,
    M_SCL  = 4'd9
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_READ1, S_READ2, S_WB, S_DONE
  } state_e;
endpackage

// File: rtl/opf_regfile.sv
module opf_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [RIW-1:0] ra_idx_i,
  input  logic [RIW-1:0] rb_idx_i,
  input  logic [RIW-1:0] rc_idx_i,
  output logic [DW-1:0]  ra_o,
  output logic [DW-1:0]  rb_o,
  output logic [DW-1:0]  rc_o,
  input  logic           wa_en_i,
  input  logic [RIW-1:0] wa_idx_i,
  input  logic [DW-1:0]  wa_data_i,
  input  logic           wb_en_i,
  input  logic [RIW-1:0] wb_idx_i,
  input  logic [DW-1:0]  wb_data_i
);
  logic [DW-1:0] rv [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign rv[g] = '0;
    end else begin : g_store
      logic [DW-1:0] q;
      // port a (sum) has priority over port b (base update)
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  q <= '0;
        else if (wa_en_i && wa_idx_i == RIW'(g))      q <= wa_data_i;
        else if (wb_en_i && wb_idx_i == RIW'(g))      q <= wb_data_i;
      end
      assign rv[g] = q;
    end
  end

  assign ra_o = rv[ra_idx_i];
  assign rb_o = rv[rb_idx_i];
  assign rc_o = rv[rc_idx_i];
endmodule

// File: rtl/opf_agen.sv
module opf_agen
  import opf_pkg::*;
#(
  parameter int DW = 32
) (
  input  mode_e         mode_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] index_i,
  input  logic [DW-1:0] imm_i,
  input  logic [1:0]    size_i,
  output logic [DW-1:0] ea_o,
  output logic          mem_o,
  output logic          two_rd_o,
  output logic [DW-1:0] direct_op_o,
  output logic          base_upd_o,
  output logic [DW-1:0] base_new_o
);
  logic [DW-1:0] dsz;
  assign dsz = DW'(1) << size_i;

  always_comb begin
    ea_o        = '0;
    mem_o       = 1'b1;
    two_rd_o    = 1'b0;
    direct_op_o = '0;
    base_upd_o  = 1'b0;
    base_new_o  = base_i;
    unique case (mode_i)
      M_REG:  begin mem_o = 1'b0; direct_op_o = base_i; end
      M_IMM:  begin mem_o = 1'b0; direct_op_o = imm_i;  end
      M_DISP: ea_o = base_i + imm_i;
      M_RIND: ea_o = base_i;
      M_IDX:  ea_o = base_i + index_i;
      M_DIR:  ea_o = imm_i;
      M_MIND: begin ea_o = base_i; two_rd_o = 1'b1; end
      M_AINC: begin ea_o = base_i; base_upd_o = 1'b1; base_new_o = base_i + dsz; end
      M_ADEC: begin ea_o = base_i - dsz; base_upd_o = 1'b1; base_new_o = base_i - dsz; end
      M_SCL:  ea_o = imm_i + base_i + (index_i << size_i);
      default: begin mem_o = 1'b0; direct_op_o = base_i; end
    endcase
  end
endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
  import opf_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [3:0]     mode_i,
  input  logic [RIW-1:0] rd_i,
  input  logic [RIW-1:0] rb_i,
  input  logic [RIW-1:0] rx_i,
  input  logic [DW-1:0]  imm_i,
  input  logic [1:0]     size_i,
  output mode_e          mode_q_o,
  output logic [RIW-1:0] rd_q_o,
  output logic [RIW-1:0] rb_q_o,
  output logic [RIW-1:0] rx_q_o,
  output logic [DW-1:0]  imm_q_o,
  output logic [1:0]     size_q_o,
  input  logic [DW-1:0]  ea_i,
  input  logic           mem_i,
  input  logic           two_rd_i,
  input  logic [DW-1:0]  direct_op_i,
  input  logic           base_upd_i,
  input  logic [DW-1:0]  base_new_i,
  input  logic [DW-1:0]  rd_val_i,
  output logic           mem_req_o,
  output logic [DW-1:0]  mem_addr_o,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_valid_i,
  output logic           wa_en_o,
  output logic [RIW-1:0] wa_idx_o,
  output logic [DW-1:0]  wa_data_o,
  output logic           wb_en_o,
  output logic [RIW-1:0] wb_idx_o,
  output logic [DW-1:0]  wb_data_o,
  output logic           busy_o,
  output logic           done_o
);
  state_e        state_q;
  logic [DW-1:0] addr_q, opnd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      mode_q_o <= M_REG;
      rd_q_o   <= '0;
      rb_q_o   <= '0;
      rx_q_o   <= '0;
      imm_q_o  <= '0;
      size_q_o <= '0;
      addr_q   <= '0;
      opnd_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          mode_q_o <= mode_e'(mode_i);
          rd_q_o   <= rd_i;
          rb_q_o   <= rb_i;
          rx_q_o   <= rx_i;
          imm_q_o  <= imm_i;
          size_q_o <= size_i;
          state_q  <= S_ADDR;
        end
        S_ADDR: begin
          if (mem_i) begin
            addr_q  <= ea_i;
            state_q <= S_READ1;
          end else begin
            opnd_q  <= direct_op_i;
            state_q <= S_WB;
          end
        end
        S_READ1: if (mem_valid_i) begin
          if (two_rd_i) begin
            addr_q  <= mem_rdata_i;  // pointer for second read
            state_q <= S_READ2;
          end else begin
            opnd_q  <= mem_rdata_i;
            state_q <= S_WB;
          end
        end
        S_READ2: if (mem_valid_i) begin
          opnd_q  <= mem_rdata_i;
          state_q <= S_WB;
        end
        S_WB:    state_q <= S_DONE;
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q == S_READ1) || (state_q == S_READ2);
  assign mem_addr_o = addr_q;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);

  assign wa_en_o    = (state_q == S_WB);
  assign wa_idx_o   = rd_q_o;
  assign wa_data_o  = rd_val_i + opnd_q;
  assign wb_en_o    = (state_q == S_WB) && base_upd_i;
  assign wb_idx_o   = rb_q_o;
  assign wb_data_o  = base_new_i;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
  AST_NOMEM_NOREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (mode_q_o == M_IMM || mode_q_o == M_REG) |-> !mem_req_o); // R3
  AST_READ2_MIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_READ2 |-> mode_q_o == M_MIND); // R6
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o); // R1
  AST_DONE_AFTER_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(wa_en_o)); // R12
endmodule

// File: rtl/opf_unit.sv
module opf_unit
  import opf_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [3:0]     mode_i,
  input  logic [RIW-1:0] rd_i,
  input  logic [RIW-1:0] rb_i,
  input  logic [RIW-1:0] rx_i,
  input  logic [DW-1:0]  imm_i,
  input  logic [1:0]     size_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           mem_req_o,
  output logic [DW-1:0]  mem_addr_o,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_valid_i
);
  mode_e          mode_q;
  logic [RIW-1:0] rd_q, rb_q, rx_q;
  logic [DW-1:0]  imm_q;
  logic [1:0]     size_q;
  logic [DW-1:0]  rd_val, rb_val, rx_val;
  logic [DW-1:0]  ea, direct_op, base_new;
  logic           need_mem, two_rd, base_upd;
  logic           wa_en, wb_en;
  logic [RIW-1:0] wa_idx, wb_idx;
  logic [DW-1:0]  wa_data, wb_data;

  opf_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni,
    .ra_idx_i(rd_q), .rb_idx_i(rb_q), .rc_idx_i(rx_q),
    .ra_o(rd_val), .rb_o(rb_val), .rc_o(rx_val),
    .wa_en_i(wa_en), .wa_idx_i(wa_idx), .wa_data_i(wa_data),
    .wb_en_i(wb_en), .wb_idx_i(wb_idx), .wb_data_i(wb_data)
  );

  opf_agen #(.DW(DW)) u_agen (
    .mode_i(mode_q), .base_i(rb_val), .index_i(rx_val), .imm_i(imm_q),
    .size_i(size_q), .ea_o(ea), .mem_o(need_mem), .two_rd_o(two_rd),
    .direct_op_o(direct_op), .base_upd_o(base_upd), .base_new_o(base_new)
  );

  opf_ctrl #(.DW(DW), .NREG(NREG)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .mode_i, .rd_i, .rb_i, .rx_i, .imm_i, .size_i,
    .mode_q_o(mode_q), .rd_q_o(rd_q), .rb_q_o(rb_q), .rx_q_o(rx_q),
    .imm_q_o(imm_q), .size_q_o(size_q),
    .ea_i(ea), .mem_i(need_mem), .two_rd_i(two_rd), .direct_op_i(direct_op),
    .base_upd_i(base_upd), .base_new_i(base_new), .rd_val_i(rd_val),
    .mem_req_o, .mem_addr_o, .mem_rdata_i, .mem_valid_i,
    .wa_en_o(wa_en), .wa_idx_o(wa_idx), .wa_data_o(wa_data),
    .wb_en_o(wb_en), .wb_idx_o(wb_idx), .wb_data_o(wb_data),
    .busy_o, .done_o
  );

  AST_R0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q == '0 |-> rd_val == '0); // R11
  AST_BASE_FIXED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !wa_en && !wb_en); // R10
endmodule

// File: tb/tb_opf_unit.sv
module tb_opf_unit;
  localparam int PERIOD = 10;
  localparam int DW = 32;
  localparam int LAT = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [3:0] mode_i = '0;
  logic [2:0] rd_i = '0, rb_i = '0, rx_i = '0;
  logic [DW-1:0] imm_i = '0;
  logic [1:0] size_i = '0;
  logic busy_o, done_o, mem_req_o;
  logic [DW-1:0] mem_addr_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic mem_valid_i = 1'b0;

  int checks = 0, errors = 0;
  int nreq, ndone;
  logic [DW-1:0] req_addr [2];
  bit stable_ok, pulse_ok, timeout;
  logic [DW-1:0] exp_reg [8];

  always #(PERIOD/2) clk = ~clk;

  opf_unit dut (
    .clk_i(clk), .rst_ni, .start_i, .mode_i, .rd_i, .rb_i, .rx_i, .imm_i, .size_i,
    .busy_o, .done_o, .mem_req_o, .mem_addr_o, .mem_rdata_i, .mem_valid_i
  );

  function automatic logic [DW-1:0] memf(input logic [DW-1:0] a);
    return a * 5 + 32'd7;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] m, input int rd, input int rb, input int rx,
                       input logic [DW-1:0] imm, input logic [1:0] sz);
    int wt, cyc;
    bit seen;
    logic [DW-1:0] last;
    @(negedge clk);
    mode_i = m; rd_i = 3'(rd); rb_i = 3'(rb); rx_i = 3'(rx); imm_i = imm; size_i = sz;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    nreq = 0; ndone = 0; wt = 0; cyc = 0; seen = 0; last = '0;
    stable_ok = 1; pulse_ok = 1; timeout = 0;
    req_addr[0] = '0; req_addr[1] = '0;
    while (!seen && cyc < 100) begin
      if (done_o) begin ndone++; seen = 1; end
      if (mem_valid_i) begin
        mem_valid_i = 1'b0;
        wt = 0;
      end else if (mem_req_o) begin
        if (wt > 0 && mem_addr_o != last) stable_ok = 0;
        last = mem_addr_o;
        if (wt == LAT) begin
          mem_valid_i = 1'b1;
          mem_rdata_i = memf(mem_addr_o);
          if (nreq < 2) req_addr[nreq] = mem_addr_o;
          nreq++;
          wt = 0;
        end else wt++;
      end
      @(negedge clk);
      cyc++;
    end
    if (done_o) pulse_ok = 0;
    if (!seen) timeout = 1;
    chk(!timeout, "R12 command completes", DW'(cyc), DW'(100));
  endtask

  task automatic setr(input int r, input logic [DW-1:0] v);
    issue(4'd1, r, 0, 0, v - exp_reg[r], 2'd0);
    if (r != 0) exp_reg[r] = v;
  endtask

  function automatic logic [DW-1:0] peek_val();
    return req_addr[0];
  endfunction

  task automatic peek(input int r, output logic [DW-1:0] v);
    issue(4'd3, 0, r, 0, '0, 2'd0);
    v = req_addr[0];
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    bit ok;
    chk(!busy_o && !done_o && !mem_req_o, "R1 idle outputs", {29'd0, busy_o, done_o, mem_req_o}, '0);
    ok = 1;
    for (int r = 1; r < 8; r++) begin
      peek(r, v);
      if (v != 0) ok = 0;
    end
    chk(ok, "R1 registers zero", v, '0);
  endtask

  task automatic t_imm();
    logic [DW-1:0] v;
    setr(1, 32'd100);
    chk(nreq == 0, "R3 no request", DW'(nreq), 0);
    chk(ndone == 1 && pulse_ok, "R12 single done", DW'(ndone), 1);
    peek(1, v);
    chk(v == 32'd100, "R3 immediate sum", v, 32'd100);
  endtask

  task automatic t_reg();
    logic [DW-1:0] v;
    setr(2, 32'd23);
    issue(4'd0, 1, 2, 0, 32'hDEAD, 2'd0);
    chk(nreq == 0, "R2 no request", DW'(nreq), 0);
    exp_reg[1] = 32'd123;
    peek(1, v);
    chk(v == 32'd123, "R2 register sum", v, 32'd123);
  endtask

  task automatic t_disp();
    logic [DW-1:0] v;
    setr(3, 32'h1000);
    issue(4'd2, 4, 3, 0, 32'h20, 2'd0);
    chk(req_addr[0] == 32'h1020, "R4 displacement addr", req_addr[0], 32'h1020);
    exp_reg[4] = memf(32'h1020);
    peek(4, v);
    chk(v == exp_reg[4], "R4 displacement sum", v, exp_reg[4]);
    issue(4'd3, 5, 3, 0, 32'h77, 2'd0);
    chk(req_addr[0] == 32'h1000, "R4 register indirect addr", req_addr[0], 32'h1000);
    exp_reg[5] = memf(32'h1000);
    chk(stable_ok, "R12 address stable", '0, '0);
  endtask

  task automatic t_idx();
    logic [DW-1:0] v;
    issue(4'd4, 5, 3, 2, '0, 2'd0);
    chk(req_addr[0] == 32'h1017, "R5 indexed addr", req_addr[0], 32'h1017);
    exp_reg[5] = exp_reg[5] + memf(32'h1017);
    peek(5, v);
    chk(v == exp_reg[5], "R5 indexed sum", v, exp_reg[5]);
    issue(4'd5, 6, 3, 2, 32'h4444, 2'd0);
    chk(req_addr[0] == 32'h4444, "R5 direct addr", req_addr[0], 32'h4444);
    exp_reg[6] = memf(32'h4444);
  endtask

  task automatic t_mind();
    logic [DW-1:0] v, p;
    p = memf(32'h1000);
    issue(4'd6, 6, 3, 0, '0, 2'd0);
    chk(nreq == 2 && req_addr[0] == 32'h1000, "R6 first read at base", req_addr[0], 32'h1000);
    chk(req_addr[1] == p, "R6 second read at pointer", req_addr[1], p);
    exp_reg[6] = exp_reg[6] + memf(p);
    peek(6, v);
    chk(v == exp_reg[6], "R6 indirect sum", v, exp_reg[6]);
    chk(stable_ok, "R12 address stable two reads", '0, '0);
  endtask

  task automatic t_ainc();
    logic [DW-1:0] v;
    issue(4'd7, 7, 3, 0, '0, 2'd2);
    chk(req_addr[0] == 32'h1000, "R7 read at old base", req_addr[0], 32'h1000);
    exp_reg[7] = memf(32'h1000);
    peek(3, v);
    chk(v == 32'h1004, "R7 base incremented", v, 32'h1004);
    peek(7, v);
    chk(v == exp_reg[7], "R7 sum", v, exp_reg[7]);
    exp_reg[3] = 32'h1004;
  endtask

  task automatic t_adec();
    logic [DW-1:0] v;
    issue(4'd8, 7, 3, 0, '0, 2'd3);
    chk(req_addr[0] == 32'h0FFC, "R8 read at decremented base", req_addr[0], 32'h0FFC);
    exp_reg[7] = exp_reg[7] + memf(32'h0FFC);
    exp_reg[3] = 32'h0FFC;
    peek(3, v);
    chk(v == 32'h0FFC, "R8 base decremented", v, 32'h0FFC);
  endtask

  task automatic t_scl();
    logic [DW-1:0] e;
    e = 32'h10 + 32'h0FFC + (32'd23 << 1);
    issue(4'd9, 5, 3, 2, 32'h10, 2'd1);
    chk(req_addr[0] == e, "R9 scaled addr d=2", req_addr[0], e);
    e = 32'h10 + 32'h0FFC + (32'd23 << 3);
    issue(4'd9, 5, 3, 2, 32'h10, 2'd3);
    chk(req_addr[0] == e, "R9 scaled addr d=8", req_addr[0], e);
  endtask

  task automatic t_same();
    logic [DW-1:0] v, e;
    e = 32'h0FFC + memf(32'h0FFC);
    issue(4'd7, 3, 3, 0, '0, 2'd0);
    peek(3, v);
    chk(v == e, "R10 sum wins over base update", v, e);
    exp_reg[3] = e;
  endtask

  task automatic t_r0();
    logic [DW-1:0] v;
    issue(4'd1, 0, 0, 0, 32'd55, 2'd0);
    peek(0, v);
    chk(v == '0, "R11 r0 stays zero", v, '0);
    issue(4'd0, 1, 0, 0, '0, 2'd0);
    peek(1, v);
    chk(v == exp_reg[1], "R11 r0 reads zero", v, exp_reg[1]);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 8; r++) exp_reg[r] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_imm();
    t_reg();
    t_disp();
    t_idx();
    t_mind();
    t_ainc();
    t_adec();
    t_scl();
    t_same();
    t_r0();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule